// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a two-part logical address (a segment number and an offset inside that segment) into a flat physical address. The segment descriptors are not held in the block. They sit in a table in memory, and each entry is a base/limit pair. Two programmable registers describe the table: the start address of the table, and the number of segments in it.

For each accepted request the block first checks the segment number against the table length. A segment number out of range traps at once and no memory read is issued. For a legal segment number, the block reads the descriptor in one memory transaction. It then compares the offset with the descriptor's limit. The result is either the base plus the offset, or a trap whose cause code tells the two kinds of fault apart. Only one translation is handled at a time.

Top module: `segxlate_unit`

## Requirements
- R1: After a synchronous active-low reset, req_ready is 1, and res_valid and mem_rd_valid are 0. The table start register and the table length register both clear to 0, so the first request traps as a bad segment.
- R2: A cycle with cfg_we high writes a register. cfg_sel 0 writes the table start address (all AW bits of cfg_wdata). cfg_sel 1 writes the table length (the low SW+1 bits of cfg_wdata). The new value applies to requests accepted after the write.
- R3: A request whose segment number is not less than the table length completes with res_trap 1, res_cause 2'b01 and res_paddr 0, and the block issues no memory read for it.
- R4: For a legal segment number, the block issues exactly one descriptor read, at address table start + segment × ENTRY_BYTES (8 by default). mem_rd_valid and mem_rd_addr stay stable until mem_rd_ready is seen high.
- R5: The descriptor returned on mem_rsp_data, in the cycle mem_rsp_valid is high, carries the segment base in bits [AW-1:0] and the segment limit (the segment length) in bits [2*AW-1:AW].
- R6: When the offset is strictly less than the limit, the result is res_trap 0, res_cause 2'b00 and res_paddr = base + offset, taken modulo 2^AW.
- R7: When the offset is greater than or equal to the limit (including any offset when the limit is 0), the result is res_trap 1, res_cause 2'b10 and res_paddr 0.
- R8: req_ready is low from the accepting edge until the cycle after the result. res_valid is high for exactly one cycle per accepted request, and a bad-segment result appears in the cycle right after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the table start register, 1 selects the table length register |
| cfg_wdata | input | AW | Register write value |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_seg | input | SW | Segment number of the logical address |
| req_off | input | OW | Offset of the logical address |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | AW | Descriptor address |
| mem_rsp_valid | input | 1 | Descriptor data valid |
| mem_rsp_data | input | 2*AW | Descriptor: {limit, base} |
| res_valid | output | 1 | Result valid, one cycle |
| res_trap | output | 1 | Translation faulted |
| res_cause | output | 2 | 00 none, 01 bad segment, 10 offset overflow |
| res_paddr | output | AW | Physical address, 0 on a trap |

## Verification
Suppose the length register or the legality check goes wrong. A bad segment then shows up either as a descriptor read that should not happen or as a missing trap, and this is visible in the very next cycle after acceptance. A wrong descriptor address appears at the memory port in the first cycle of the fetch. A wrong limit comparison or base sum is seen one cycle after the response, on res_paddr and res_cause. A sequencer that lingers or skips a state shows up as req_ready rising while a result is still owed, or as a res_valid pulse with nothing pending.

// File: rtl/segxlate_pkg.sv
// Shared types for the segment table address translator.
// Assumes: cause encodings are visible at the top-level port as raw bits.
package segxlate_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'b00,
        CAUSE_BADSEG   = 2'b01,
        CAUSE_OVERFLOW = 2'b10
    } trap_cause_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_DONE
    } xl_state_e;

endpackage

// File: rtl/seg_bound_chk.sv
// Decides whether a segment number lies inside the programmed table.
// Assumes: the length is one bit wider than the segment number, so a full table fits.
module seg_bound_chk #(
    parameter int SW = 8
) (
    input  logic [SW-1:0] seg,
    input  logic [SW:0]   tbl_len,
    output logic          legal
);
    // legal only when the segment index is below the table length
    always_comb legal = ({1'b0, seg} < tbl_len);
endmodule

// File: rtl/seg_entry_addr.sv
// Forms the memory address of one descriptor from the table start and segment number.
// Assumes: ENTRY_BYTES is a power of two and SW < AW.
module seg_entry_addr #(
    parameter int AW          = 32,
    parameter int SW          = 8,
    parameter int ENTRY_BYTES = 8
) (
    input  logic [AW-1:0] tbl_base,
    input  logic [SW-1:0] seg,
    output logic [AW-1:0] entry_addr
);
    localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);

    logic [AW-1:0] seg_ext;

    // widen the index, scale it by the descriptor size and add the table start
    always_comb begin
        seg_ext    = {{(AW-SW){1'b0}}, seg};
        entry_addr = tbl_base + (seg_ext << ENTRY_SHIFT);
    end
endmodule

// File: rtl/seg_limit_chk.sv
// Checks an offset against a segment limit and forms the physical address.
// Assumes: OW <= AW; the sum wraps modulo 2^AW.
module seg_limit_chk #(
    parameter int AW = 32,
    parameter int OW = 16
) (
    input  logic [AW-1:0] seg_base,
    input  logic [AW-1:0] seg_limit,
    input  logic [OW-1:0] off,
    output logic          fits,
    output logic [AW-1:0] paddr
);
    logic [AW-1:0] off_ext;

    // offset must be strictly below the limit; address is base plus offset
    always_comb begin
        off_ext = {{(AW-OW){1'b0}}, off};
        fits    = (off_ext < seg_limit);
        paddr   = seg_base + off_ext;
    end
endmodule

// File: rtl/segxlate_unit.sv
// Segment table address translator: holds the table start/length registers,
// sequences one descriptor fetch per legal request and reports result or trap.
// Assumes: one translation in flight; the memory returns one response per read;
// res_valid is a single-cycle pulse with no back-pressure.
module segxlate_unit
    import segxlate_pkg::*;
#(
    parameter int AW          = 32,
    parameter int SW          = 8,
    parameter int OW          = 16,
    parameter int ENTRY_BYTES = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic            cfg_sel,
    input  logic [AW-1:0]   cfg_wdata,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [SW-1:0]   req_seg,
    input  logic [OW-1:0]   req_off,
    output logic            mem_rd_valid,
    input  logic            mem_rd_ready,
    output logic [AW-1:0]   mem_rd_addr,
    input  logic            mem_rsp_valid,
    input  logic [2*AW-1:0] mem_rsp_data,
    output logic            res_valid,
    output logic            res_trap,
    output logic [1:0]      res_cause,
    output logic [AW-1:0]   res_paddr
);
    localparam int LW = SW + 1;

    xl_state_e   state_q;
    logic [AW-1:0] tbl_base_q;
    logic [LW-1:0] tbl_len_q;
    logic [SW-1:0] seg_q;
    logic [OW-1:0] off_q;
    logic          trap_q;
    trap_cause_e   cause_q;
    logic [AW-1:0] paddr_q;

    logic          seg_legal;
    logic          off_fits;
    logic [AW-1:0] sum_paddr;
    logic [AW-1:0] entry_addr;

    seg_bound_chk #(.SW(SW)) u_bound (
        .seg     (req_seg),
        .tbl_len (tbl_len_q),
        .legal   (seg_legal)
    );

    seg_entry_addr #(.AW(AW), .SW(SW), .ENTRY_BYTES(ENTRY_BYTES)) u_addr (
        .tbl_base   (tbl_base_q),
        .seg        (seg_q),
        .entry_addr (entry_addr)
    );

    seg_limit_chk #(.AW(AW), .OW(OW)) u_limit (
        .seg_base  (mem_rsp_data[AW-1:0]),
        .seg_limit (mem_rsp_data[2*AW-1:AW]),
        .off       (off_q),
        .fits      (off_fits),
        .paddr     (sum_paddr)
    );

    // programmable table start and length registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_base_q <= '0;
            tbl_len_q  <= '0;
        end else if (cfg_we) begin
            if (cfg_sel) tbl_len_q  <= cfg_wdata[LW-1:0];
            else         tbl_base_q <= cfg_wdata;
        end
    end

    // request capture, descriptor fetch sequencing and result formation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            seg_q   <= '0;
            off_q   <= '0;
            trap_q  <= 1'b0;
            cause_q <= CAUSE_NONE;
            paddr_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    seg_q <= req_seg;
                    off_q <= req_off;
                    if (seg_legal) begin
                        state_q <= ST_FETCH;
                    end else begin
                        trap_q  <= 1'b1;
                        cause_q <= CAUSE_BADSEG;
                        paddr_q <= '0;
                        state_q <= ST_DONE;
                    end
                end
                ST_FETCH: if (mem_rd_ready) state_q <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    trap_q  <= !off_fits;
                    cause_q <= off_fits ? CAUSE_NONE : CAUSE_OVERFLOW;
                    paddr_q <= off_fits ? sum_paddr : '0;
                    state_q <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // handshake and result outputs
    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        mem_rd_valid = (state_q == ST_FETCH);
        mem_rd_addr  = entry_addr;
        res_valid    = (state_q == ST_DONE);
        res_trap     = trap_q;
        res_cause    = cause_q;
        res_paddr    = paddr_q;
    end

    // R3
    badseg_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && ({1'b0, req_seg} >= tbl_len_q))
        |=> (!mem_rd_valid && res_valid && res_trap && res_cause == CAUSE_BADSEG));

    // R4
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // R8
    res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (!res_valid && req_ready));

    // R8
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R7
    trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_trap) |-> (res_cause != CAUSE_NONE && res_paddr == '0));

    // R6
    ok_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_trap) |-> (res_cause == CAUSE_NONE));

endmodule

// File: tb/segxlate_unit_test.sv
module segxlate_unit_test;
    localparam int AW = 32;
    localparam int SW = 8;
    localparam int OW = 16;

    typedef struct packed {
        logic        trap;
        logic [1:0]  cause;
        logic [31:0] paddr;
        logic [31:0] reads;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic            cfg_sel = 1'b0;
    logic [AW-1:0]   cfg_wdata = '0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [SW-1:0]   req_seg = '0;
    logic [OW-1:0]   req_off = '0;
    logic            mem_rd_valid;
    logic            mem_rd_ready = 1'b0;
    logic [AW-1:0]   mem_rd_addr;
    logic            mem_rsp_valid = 1'b0;
    logic [2*AW-1:0] mem_rsp_data = '0;
    logic            res_valid;
    logic            res_trap;
    logic [1:0]      res_cause;
    logic [AW-1:0]   res_paddr;

    int tests = 0;
    int fails = 0;
    int rd_count = 0;
    int rd_expected = 0;
    logic [31:0] b_base = 0;
    int b_len = 0;
    bit done = 0;
    exp_t exp_q[$];
    logic [31:0] fetch_q[$];

    always #5 clk = ~clk;

    segxlate_unit uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_seg(req_seg), .req_off(req_off), .mem_rd_valid(mem_rd_valid),
        .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .res_valid(res_valid), .res_trap(res_trap), .res_cause(res_cause),
        .res_paddr(res_paddr)
    );

    function automatic logic [31:0] ent_base(input int i);
        return 32'h0001_0000 * (i + 1) + i * 16;
    endfunction

    function automatic logic [31:0] ent_lim(input int i);
        if (i == 2) return 32'h0;
        if (i == 3) return 32'h0002_0000;
        return 32'h100 * (i + 1);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input bit sel, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        if (sel) b_len = int'(val[8:0]); else b_base = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // driver: computes the expected result from the requirements and queues it
    task automatic send(input logic [7:0] s, input logic [15:0] o);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        if (int'(s) < b_len) begin
            rd_expected++;
            fetch_q.push_back(b_base + 32'(s) * 8);
            if (32'(o) < ent_lim(int'(s))) begin
                e.trap = 1'b0; e.cause = 2'b00; e.paddr = ent_base(int'(s)) + 32'(o);
            end else begin
                e.trap = 1'b1; e.cause = 2'b10; e.paddr = 32'h0;
            end
        end else begin
            e.trap = 1'b1; e.cause = 2'b01; e.paddr = 32'h0;
        end
        e.reads = 32'(rd_expected);
        exp_q.push_back(e);
        req_valid = 1'b1; req_seg = s; req_off = o;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // memory model: variable ready and response latency, checks fetch address
    initial begin
        int ph = 0;
        int cnt = 0;
        logic [31:0] a = 0;
        forever begin
            @(negedge clk);
            case (ph)
                0: if (mem_rd_valid) begin
                    if (cnt < rd_count % 3) cnt++;
                    else begin mem_rd_ready = 1'b1; a = mem_rd_addr; ph = 1; end
                end
                1: begin
                    mem_rd_ready = 1'b0;
                    rd_count++;
                    if (fetch_q.size() == 0)
                        chk(1'b0, "R3 unexpected descriptor read", 64'(a), 64'h0);
                    else begin
                        logic [31:0] ea;
                        ea = fetch_q.pop_front();
                        chk(a == ea, "R4 descriptor address", 64'(a), 64'(ea));
                    end
                    cnt = rd_count % 2;
                    ph = 2;
                end
                2: if (cnt == 0) begin
                    int idx;
                    idx = int'((a - b_base) >> 3) & 255;
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data = {ent_lim(idx), ent_base(idx)};
                    ph = 3;
                end else cnt--;
                default: begin
                    mem_rsp_valid = 1'b0; cnt = 0; ph = 0;
                end
            endcase
        end
    end

    // monitor: pops expected items as results appear, checks busy behaviour
    initial begin
        forever begin
            @(posedge clk); #2;
            if (rst_n) begin
                if (res_valid) begin
                    if (exp_q.size() == 0)
                        chk(1'b0, "R8 result with nothing pending", 64'(res_paddr), 64'h0);
                    else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk(res_trap == e.trap, "R3/R6/R7 trap flag", 64'(res_trap), 64'(e.trap));
                        chk(res_cause == e.cause, "R3/R6/R7 cause", 64'(res_cause), 64'(e.cause));
                        chk(res_paddr == e.paddr, "R5/R6 physical address", 64'(res_paddr), 64'(e.paddr));
                        chk(32'(rd_count) == e.reads, "R3 read count", 64'(rd_count), 64'(e.reads));
                        chk(!req_ready, "R8 ready low with result", 64'(req_ready), 64'h0);
                    end
                end else if (exp_q.size() != 0) begin
                    chk(!req_ready, "R8 ready low while busy", 64'(req_ready), 64'h0);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 req_ready after reset", 64'(req_ready), 64'h1);
        chk(res_valid == 1'b0, "R1 res_valid after reset", 64'(res_valid), 64'h0);
        chk(mem_rd_valid == 1'b0, "R1 mem_rd_valid after reset", 64'(mem_rd_valid), 64'h0);
        send(8'd0, 16'h0);                      // R1: length 0 -> bad segment

        cfg_write(1'b0, 32'h0000_2000);         // R2
        cfg_write(1'b1, 32'd5);
        send(8'd0, 16'h0);                      // R6
        send(8'd0, 16'h00FF);                   // R6 limit-1
        send(8'd0, 16'h0100);                   // R7 offset == limit
        send(8'd1, 16'h01FF);
        send(8'd2, 16'h0);                      // R7 zero limit
        send(8'd3, 16'hFFFF);                   // R6 large limit
        send(8'd4, 16'h04FF);                   // last legal segment
        send(8'd5, 16'h0);                      // R3 segment == length
        send(8'd200, 16'h3);                    // R3

        cfg_write(1'b0, 32'h0000_3008);         // R2 new table start
        cfg_write(1'b1, 32'd256);               // R2 full table
        send(8'd255, 16'h0010);
        send(8'd7, 16'h07FF);
        send(8'd4, 16'h0500);                   // R7

        cfg_write(1'b1, 32'd1);                 // R2 shrink table
        send(8'd1, 16'h0);                      // R3
        send(8'd0, 16'h0001);

        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(req_ready == 1'b1, "R8 ready after last result", 64'(req_ready), 64'h1);
        chk(rd_count == rd_expected, "R3/R4 total reads", 64'(rd_count), 64'(rd_expected));
        chk(fetch_q.size() == 0, "R4 all expected reads seen", 64'(fetch_q.size()), 64'h0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule